// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block decides which low-power mode the device enters when the processor issues a wait-for-interrupt or wait-for-event request, and it brings the device back out again. Three control bits choose among four modes: a deep-sleep select, a power-down select and a regulator low-power select. The modes are plain sleep, low-power sleep, stop and standby. The block drives the CPU and flash clock gates and the core power-off. On exit from the deep modes it signals that the multi-speed oscillator must take over as the system clock.

Deep-mode entry is refused while any wakeup-pending flag is set. It is held back while a flash program operation or a peripheral bus access is still in flight. Each mode accepts its own set of wakeup sources. Leaving standby does not resume execution: it raises a reset request. A wakeup flag and a standby flag record what happened, and each has its own clear strobe. The standby flag lives on the power-on reset and survives the system reset.

Top module: `lpm_ctrl`

## Requirements
- R1: In run mode, a request (`wfi_i` or `wfe_i` high for one cycle) with `deep_sleep_i`=0 moves `mode_o` at the next clock edge:
  - to 1 (sleep) if `reg_lp_i`=0, with the CPU clock gated and the flash clock running;
  - to 2 (low-power sleep) if `reg_lp_i`=1, with both clocks gated.
- R2: A request with `deep_sleep_i`=1, no pending flag and no activity moves `mode_o` at the next clock edge:
  - to 4 (stop) if `pwr_down_sel_i`=0, with both clocks gated;
  - to 5 (standby) if `pwr_down_sel_i`=1, with both clocks gated and `core_off_o`=1.
- R3: If any bit of `pend_i` is set when a deep request arrives, the request is dropped and `mode_o` stays 0. A pending bit that rises during deferral returns `mode_o` to 0.
- R4: If `flash_busy_i` or `bus_busy_i` is high at a deep request, `mode_o` becomes 3 (deferred), with the CPU clock gated and the flash clock running. It stays 3 while either signal is high, and it enters the selected deep mode at the first clock edge at which both are low.
- R5: Sleep and low-power sleep return to `mode_o`=0 at the next edge:
  - on `irq_i` if entered by `wfi_i`;
  - on `evt_i` if entered by `wfe_i`.
  The other line has no effect. If both request lines are high, the request counts as `wfi_i`.
- R6: Stop returns to mode 0 on any of the following: the entry-kind line of R5, `cmp_evt_i`, `rtc_alarm_i`, `rtc_wake_i`, `tamper_i` or `tstamp_i`. During the first cycle in run mode, `osc_msi_sel_o`=1 and `msi_default_o`=0.
- R7: Standby returns to mode 0 on any of the following: a rising edge of an enabled wakeup pin, `rtc_alarm_i`, `rtc_wake_i`, `tamper_i`, `tstamp_i`, `ext_rst_i` or `wdg_rst_i`. During the first cycle in run mode, `rst_req_o`, `osc_msi_sel_o` and `msi_default_o` are all 1. `cmp_evt_i` has no effect in standby.
- R8: Setting a bit of `wk_pin_en_i` while that pin is already high counts as a rising edge of that pin.
- R9: `wuf_o` is set at the clock edge that sees an enabled pin edge or any of the RTC alarm, RTC wakeup, tamper or time-stamp inputs. A one-cycle `clr_wuf_i` pulse is sampled at one edge; the flag still reads 1 after that edge and reads 0 after the next edge. `rst_ni` low clears it.
- R10: `sbf_o` is set at the edge that enters standby. It is not cleared by `rst_ni`. It is cleared by `por_ni` low, or by `clr_sbf_i` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset |
| wfi_i | input | 1 | Wait-for-interrupt request pulse |
| wfe_i | input | 1 | Wait-for-event request pulse |
| deep_sleep_i | input | 1 | Deep mode select |
| pwr_down_sel_i | input | 1 | 0 selects stop, 1 selects standby |
| reg_lp_i | input | 1 | Regulator low-power select (sleep variant) |
| pend_i | input | NPEND | Wakeup-pending flags that veto deep entry |
| flash_busy_i | input | 1 | Flash program operation in progress |
| bus_busy_i | input | 1 | Peripheral bus access in progress |
| irq_i | input | 1 | Enabled interrupt pending |
| evt_i | input | 1 | Event pulse |
| wk_pin_i | input | NPIN | Wakeup pin levels |
| wk_pin_en_i | input | NPIN | Wakeup pin enables |
| rtc_alarm_i | input | 1 | RTC alarm event |
| rtc_wake_i | input | 1 | RTC periodic wakeup event |
| tamper_i | input | 1 | Tamper event |
| tstamp_i | input | 1 | Time-stamp event |
| cmp_evt_i | input | 1 | Comparator event |
| wdg_rst_i | input | 1 | Watchdog reset event |
| ext_rst_i | input | 1 | External reset pin event |
| clr_wuf_i | input | 1 | Wakeup flag clear strobe |
| clr_sbf_i | input | 1 | Standby flag clear strobe |
| mode_o | output | 3 | 0 run, 1 sleep, 2 low-power sleep, 3 deferred, 4 stop, 5 standby |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| flash_clk_en_o | output | 1 | Flash clock enable |
| core_off_o | output | 1 | Core domain power off |
| osc_msi_sel_o | output | 1 | Select multi-speed oscillator (exit pulse) |
| msi_default_o | output | 1 | Oscillator returns to default setting |
| rst_req_o | output | 1 | Reset request after standby wakeup |
| wuf_o | output | 1 | Wakeup flag |
| sbf_o | output | 1 | Standby flag |

## Verification
The random part draws, for each request, the three mode bits, the request kind, an occasional pending flag and occasional activity. It then checks the resulting mode against a bench model, so that each bit's role and the veto-over-defer priority are separated. Every entry is followed by a wakeup drawn from the sources that mode accepts; for the sleep modes, the wrong line for the entry kind is tried first, which separates the two exit rules. The directed cases cover the following:
- a comparator event during standby, against one during stop;
- enabling a pin that is already high;
- the two-edge delay of the wakeup-flag clear;
- the standby flag surviving a system reset but not a power-on reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_RUN     = 3'd0,
    M_SLEEP   = 3'd1,
    M_LPSLEEP = 3'd2,
    M_DEFER   = 3'd3,
    M_STOP    = 3'd4,
    M_STANDBY = 3'd5
  } lpm_mode_e;
endpackage

// File: rtl/lpm_wake.sv
module lpm_wake #(
  parameter int NPIN = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] pin_en_i,
  input  logic            rtc_alarm_i,
  input  logic            rtc_wake_i,
  input  logic            tamper_i,
  input  logic            tstamp_i,
  input  logic            cmp_evt_i,
  input  logic            ext_rst_i,
  input  logic            wdg_rst_i,
  output logic            flag_set_o,
  output logic            stop_src_o,
  output logic            sby_src_o
);
  logic [NPIN-1:0] arm, arm_q, edge_hit;

  // enable-while-high counts as an edge because the armed level is tracked
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign arm[g] = pin_i[g] & pin_en_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) arm_q[g] <= 1'b0;
      else         arm_q[g] <= arm[g];
    end
    assign edge_hit[g] = arm[g] & ~arm_q[g];
  end

  logic rtc_any;
  assign rtc_any    = rtc_alarm_i | rtc_wake_i | tamper_i | tstamp_i;
  assign flag_set_o = rtc_any | (|edge_hit);
  assign stop_src_o = rtc_any | cmp_evt_i;
  assign sby_src_o  = rtc_any | (|edge_hit) | ext_rst_i | wdg_rst_i;
endmodule

// File: rtl/lpm_flags.sv
module lpm_flags #(
  parameter int CLR_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  logic wuf_set_i,
  input  logic wuf_clr_i,
  input  logic sbf_set_i,
  input  logic sbf_clr_i,
  output logic wuf_o,
  output logic sbf_o
);
  localparam int PW = (CLR_LAT > 1) ? CLR_LAT - 1 : 1;

  logic [PW-1:0] clr_pipe;
  logic          wuf_q, sbf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_pipe <= '0;
      wuf_q    <= 1'b0;
    end else begin
      clr_pipe[0] <= wuf_clr_i;
      for (int i = 1; i < PW; i++) clr_pipe[i] <= clr_pipe[i-1];
      if (wuf_set_i)          wuf_q <= 1'b1;
      else if (clr_pipe[PW-1]) wuf_q <= 1'b0;
    end
  end

  // standby flag lives on the power-on reset only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)        sbf_q <= 1'b0;
    else if (sbf_set_i) sbf_q <= 1'b1;
    else if (sbf_clr_i) sbf_q <= 1'b0;
  end

  assign wuf_o = wuf_q;
  assign sbf_o = sbf_q;
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wfi_i,
  input  logic      wfe_i,
  input  logic      deep_i,
  input  logic      pds_i,
  input  logic      reg_lp_i,
  input  logic      veto_i,
  input  logic      busy_i,
  input  logic      irq_i,
  input  logic      evt_i,
  input  logic      stop_wake_i,
  input  logic      sby_wake_i,
  output lpm_mode_e mode_o,
  output logic      cpu_clk_en_o,
  output logic      flash_clk_en_o,
  output logic      core_off_o,
  output logic      osc_sel_o,
  output logic      osc_dflt_o,
  output logic      rst_req_o,
  output logic      sby_enter_o
);
  lpm_mode_e st_q, st_n;
  logic kind_q, kind_n;   // 1: entered by event wait
  logic sby_q, sby_n;
  logic osc_q, osc_n, dflt_q, dflt_n, rreq_q, rreq_n;
  logic kind_wake, req;
  lpm_mode_e deep_tgt;

  assign req       = wfi_i | wfe_i;
  assign kind_wake = kind_q ? evt_i : irq_i;
  assign deep_tgt  = sby_q ? M_STANDBY : M_STOP;

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    sby_n  = sby_q;
    osc_n  = 1'b0;
    dflt_n = 1'b0;
    rreq_n = 1'b0;
    case (st_q)
      M_RUN: if (req) begin
        kind_n = ~wfi_i;
        sby_n  = pds_i;
        if (!deep_i)     st_n = reg_lp_i ? M_LPSLEEP : M_SLEEP;
        else if (!veto_i) st_n = busy_i ? M_DEFER : (pds_i ? M_STANDBY : M_STOP);
      end
      M_SLEEP, M_LPSLEEP: if (kind_wake) st_n = M_RUN;
      M_DEFER: begin
        if (veto_i)       st_n = M_RUN;
        else if (!busy_i) st_n = deep_tgt;
      end
      M_STOP: if (stop_wake_i || kind_wake) begin
        st_n  = M_RUN;
        osc_n = 1'b1;
      end
      M_STANDBY: if (sby_wake_i) begin
        st_n   = M_RUN;
        osc_n  = 1'b1;
        dflt_n = 1'b1;
        rreq_n = 1'b1;
      end
      default: st_n = M_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_RUN;
      kind_q <= 1'b0;
      sby_q  <= 1'b0;
      osc_q  <= 1'b0;
      dflt_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      sby_q  <= sby_n;
      osc_q  <= osc_n;
      dflt_q <= dflt_n;
      rreq_q <= rreq_n;
    end
  end

  assign mode_o         = st_q;
  assign cpu_clk_en_o   = (st_q == M_RUN);
  assign flash_clk_en_o = (st_q == M_RUN) || (st_q == M_SLEEP) || (st_q == M_DEFER);
  assign core_off_o     = (st_q == M_STANDBY);
  assign osc_sel_o      = osc_q;
  assign osc_dflt_o     = dflt_q;
  assign rst_req_o      = rreq_q;
  assign sby_enter_o    = (st_n == M_STANDBY) && (st_q != M_STANDBY);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NPIN    = 3,
  parameter int NPEND   = 6,
  parameter int CLR_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             wfi_i,
  input  logic             wfe_i,
  input  logic             deep_sleep_i,
  input  logic             pwr_down_sel_i,
  input  logic             reg_lp_i,
  input  logic [NPEND-1:0] pend_i,
  input  logic             flash_busy_i,
  input  logic             bus_busy_i,
  input  logic             irq_i,
  input  logic             evt_i,
  input  logic [NPIN-1:0]  wk_pin_i,
  input  logic [NPIN-1:0]  wk_pin_en_i,
  input  logic             rtc_alarm_i,
  input  logic             rtc_wake_i,
  input  logic             tamper_i,
  input  logic             tstamp_i,
  input  logic             cmp_evt_i,
  input  logic             wdg_rst_i,
  input  logic             ext_rst_i,
  input  logic             clr_wuf_i,
  input  logic             clr_sbf_i,
  output logic [2:0]       mode_o,
  output logic             cpu_clk_en_o,
  output logic             flash_clk_en_o,
  output logic             core_off_o,
  output logic             osc_msi_sel_o,
  output logic             msi_default_o,
  output logic             rst_req_o,
  output logic             wuf_o,
  output logic             sbf_o
);
  logic flag_set, stop_src, sby_src, sby_enter;
  lpm_mode_e mode;

  lpm_wake #(.NPIN(NPIN)) u_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (wk_pin_i),
    .pin_en_i    (wk_pin_en_i),
    .rtc_alarm_i (rtc_alarm_i),
    .rtc_wake_i  (rtc_wake_i),
    .tamper_i    (tamper_i),
    .tstamp_i    (tstamp_i),
    .cmp_evt_i   (cmp_evt_i),
    .ext_rst_i   (ext_rst_i),
    .wdg_rst_i   (wdg_rst_i),
    .flag_set_o  (flag_set),
    .stop_src_o  (stop_src),
    .sby_src_o   (sby_src)
  );

  lpm_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wfi_i          (wfi_i),
    .wfe_i          (wfe_i),
    .deep_i         (deep_sleep_i),
    .pds_i          (pwr_down_sel_i),
    .reg_lp_i       (reg_lp_i),
    .veto_i         (|pend_i),
    .busy_i         (flash_busy_i | bus_busy_i),
    .irq_i          (irq_i),
    .evt_i          (evt_i),
    .stop_wake_i    (stop_src),
    .sby_wake_i     (sby_src),
    .mode_o         (mode),
    .cpu_clk_en_o   (cpu_clk_en_o),
    .flash_clk_en_o (flash_clk_en_o),
    .core_off_o     (core_off_o),
    .osc_sel_o      (osc_msi_sel_o),
    .osc_dflt_o     (msi_default_o),
    .rst_req_o      (rst_req_o),
    .sby_enter_o    (sby_enter)
  );

  lpm_flags #(.CLR_LAT(CLR_LAT)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_ni    (por_ni),
    .wuf_set_i (flag_set),
    .wuf_clr_i (clr_wuf_i),
    .sbf_set_i (sby_enter),
    .sbf_clr_i (clr_sbf_i),
    .wuf_o     (wuf_o),
    .sbf_o     (sbf_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/lpm_chk.sv
module lpm_chk #(
  parameter int NPIN  = 3,
  parameter int NPEND = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             wfi_i,
  input logic             wfe_i,
  input logic             deep_sleep_i,
  input logic [NPEND-1:0] pend_i,
  input logic             flash_busy_i,
  input logic             bus_busy_i,
  input logic             irq_i,
  input logic             evt_i,
  input logic [NPIN-1:0]  wk_pin_i,
  input logic [NPIN-1:0]  wk_pin_en_i,
  input logic             rtc_alarm_i,
  input logic             rtc_wake_i,
  input logic             tamper_i,
  input logic             tstamp_i,
  input logic             wdg_rst_i,
  input logic             ext_rst_i,
  input logic [2:0]       mode_o,
  input logic             rst_req_o,
  input logic             sbf_o
);
  a_r3_veto_keeps_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 && (wfi_i || wfe_i) && deep_sleep_i && (|pend_i)) |=> mode_o == 3'd0);

  a_r4_defer_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && (flash_busy_i || bus_busy_i) && !(|pend_i)) |=> mode_o == 3'd3);

  a_r5_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 && !irq_i && !evt_i) |=> mode_o == 3'd1);

  a_r7_standby_ignores_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5 && !(|(wk_pin_i & wk_pin_en_i)) && !rtc_alarm_i && !rtc_wake_i
     && !tamper_i && !tstamp_i && !ext_rst_i && !wdg_rst_i) |=> mode_o == 3'd5);

  a_r7_reset_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5 && (ext_rst_i || wdg_rst_i)) |=> (rst_req_o && mode_o == 3'd0));

  a_r10_sbf_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    ($past(mode_o) != 3'd5 && mode_o == 3'd5) |-> sbf_o);
endmodule

bind lpm_ctrl lpm_chk #(.NPIN(NPIN), .NPEND(NPEND)) u_chk (.*);

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 3;
  localparam int NPEND = 6;

  logic clk = 0, rst_ni = 0, por_ni = 0;
  logic wfi = 0, wfe = 0, deep = 0, pds = 0, rlp = 0;
  logic [NPEND-1:0] pend = '0;
  logic fbusy = 0, bbusy = 0, irq = 0, evt = 0;
  logic [NPIN-1:0] pin = '0, pen = '0;
  logic ralarm = 0, rwake = 0, tamp = 0, tst = 0, cmp = 0, wdg = 0, erst = 0;
  logic cwuf = 0, csbf = 0;
  logic [2:0] mode;
  logic cpu_en, fl_en, coff, osc, mdef, rreq, wuf, sbf;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl #(.NPIN(NPIN), .NPEND(NPEND)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .wfi_i(wfi), .wfe_i(wfe),
    .deep_sleep_i(deep), .pwr_down_sel_i(pds), .reg_lp_i(rlp), .pend_i(pend),
    .flash_busy_i(fbusy), .bus_busy_i(bbusy), .irq_i(irq), .evt_i(evt),
    .wk_pin_i(pin), .wk_pin_en_i(pen), .rtc_alarm_i(ralarm), .rtc_wake_i(rwake),
    .tamper_i(tamp), .tstamp_i(tst), .cmp_evt_i(cmp), .wdg_rst_i(wdg), .ext_rst_i(erst),
    .clr_wuf_i(cwuf), .clr_sbf_i(csbf), .mode_o(mode), .cpu_clk_en_o(cpu_en),
    .flash_clk_en_o(fl_en), .core_off_o(coff), .osc_msi_sel_o(osc),
    .msi_default_o(mdef), .rst_req_o(rreq), .wuf_o(wuf), .sbf_o(sbf));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_entry(bit d, bit p, bit lp, bit pn, bit bz);
    if (!d) return lp ? 2 : 1;
    if (pn) return 0;
    if (bz) return 3;
    return p ? 5 : 4;
  endfunction

  task automatic request(bit use_wfe);
    wfi = !use_wfe; wfe = use_wfe;
    tick();
    wfi = 0; wfe = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(); s = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    tick(); tick();
    rst_ni = 1; por_ni = 1;
    tick();
    chk("reset mode", mode, 0);
    chk("reset cpu clk", cpu_en, 1);
    chk("R9 reset wuf", wuf, 0);
    chk("R10 reset sbf", sbf, 0);

    // R1 sleep and low-power sleep, R5 exit rules
    deep = 0; rlp = 0; request(0);
    chk("R1 sleep mode", mode, 1);
    chk("R1 sleep cpu gated", cpu_en, 0);
    chk("R1 sleep flash on", fl_en, 1);
    pulse(evt);
    chk("R5 wfi ignores evt", mode, 1);
    pulse(irq);
    chk("R5 wfi exits on irq", mode, 0);
    rlp = 1; request(1);
    chk("R1 lp sleep mode", mode, 2);
    chk("R1 lp sleep flash off", fl_en, 0);
    pulse(irq);
    chk("R5 wfe ignores irq", mode, 2);
    pulse(evt);
    chk("R5 wfe exits on evt", mode, 0);
    rlp = 0;
    wfi = 1; wfe = 1; tick(); wfi = 0; wfe = 0;
    pulse(evt);
    chk("R5 both lines count as wfi", mode, 1);
    pulse(irq);
    chk("R5 both lines exit", mode, 0);

    // R2 stop, R6 exits
    deep = 1; pds = 0; request(0);
    chk("R2 stop mode", mode, 4);
    chk("R2 stop flash off", fl_en, 0);
    pulse(cmp);
    chk("R6 stop cmp exit", mode, 0);
    chk("R6 osc select", osc, 1);
    chk("R6 msi kept", mdef, 0);
    tick();
    chk("R6 osc pulse ends", osc, 0);

    // R3 veto
    pend = 6'b000100; request(0);
    chk("R3 pend veto", mode, 0);
    pend = '0;
    // R4 defer then veto
    fbusy = 1; request(0);
    chk("R4 defer", mode, 3);
    tick();
    chk("R4 still defer", mode, 3);
    pend = 6'b100000; tick(); pend = '0;
    chk("R3 veto during defer", mode, 0);
    fbusy = 0;

    // R2 standby, R7 cmp ignored, R10 flag
    pds = 1; bbusy = 1; request(0);
    chk("R4 bus defer", mode, 3);
    bbusy = 0; tick();
    chk("R4 enter standby after idle", mode, 5);
    chk("R2 core off", coff, 1);
    chk("R10 sbf set", sbf, 1);
    pulse(cmp);
    chk("R7 cmp ignored in standby", mode, 5);
    chk("R7 no reset request", rreq, 0);
    // R8 enable while high
    pin = 3'b010; tick();
    chk("R8 disabled pin no wake", mode, 5);
    pen = 3'b010; tick();
    chk("R8 enable-high wakes", mode, 0);
    chk("R7 reset request", rreq, 1);
    chk("R7 msi default", mdef, 1);
    chk("R9 wuf set by pin", wuf, 1);
    pin = 0; pen = 0;
    // R9 clear latency
    cwuf = 1; tick(); cwuf = 0;
    chk("R9 wuf held one cycle", wuf, 1);
    tick();
    chk("R9 wuf cleared", wuf, 0);
    // R10 survives system reset; R9 reset clears wuf
    pulse(tamp);
    chk("R9 wuf set by tamper", wuf, 1);
    rst_ni = 0; tick(); rst_ni = 1; tick();
    chk("R10 sbf survives rst", sbf, 1);
    chk("R9 wuf cleared by rst", wuf, 0);
    pulse(csbf);
    chk("R10 sbf strobe clear", sbf, 0);
    request(0);
    chk("R2 standby again", mode, 5);
    pulse(wdg);
    chk("R7 wdg wake", mode, 0);
    por_ni = 0; tick(); por_ni = 1; tick();
    chk("R10 sbf por clear", sbf, 0);

    // random section
    for (int it = 0; it < 60; it++) begin
      bit d, p, lp, pn, bz, k;
      int e;
      d = $urandom_range(0, 1); p = $urandom_range(0, 1); lp = $urandom_range(0, 1);
      k = $urandom_range(0, 1);
      pn = ($urandom_range(0, 4) == 0); bz = ($urandom_range(0, 2) == 0);
      deep = d; pds = p; rlp = lp;
      pend = pn ? NPEND'(1) << $urandom_range(0, NPEND-1) : '0;
      fbusy = bz & $urandom_range(0, 1); bbusy = bz & !fbusy;
      request(k);
      pend = '0;
      e = exp_entry(d, p, lp, pn, bz);
      chk("R1 R2 R3 R4 random entry", mode, e);
      if (e == 3) begin
        fbusy = 0; bbusy = 0; tick();
        e = p ? 5 : 4;
        chk("R4 random release", mode, e);
      end
      fbusy = 0; bbusy = 0;
      if (e == 1 || e == 2) begin
        if (k) pulse(irq); else pulse(evt);
        chk("R5 random wrong line", mode, e);
        if (k) pulse(evt); else pulse(irq);
        chk("R5 random exit", mode, 0);
      end else if (e == 4) begin
        if ($urandom_range(0, 1) == 1) pulse(rwake);
        else if (k) pulse(evt); else pulse(irq);
        chk("R6 random stop exit", mode, 0);
      end else if (e == 5) begin
        pulse(ralarm);
        chk("R7 random standby exit", mode, 0);
        chk("R7 random reset request", rreq, 1);
      end
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule